// File: doc/BRIEF.md
# Stepped-Setting PWM Generator

This block produces one open-loop gate pulse train. Two settings control it, both kept as step indices. The switching frequency runs from 50 kHz to 200 kHz in 10 kHz steps, which gives 16 settings. The duty ratio runs from 0 to 0.9 in steps of 0.025, which gives 37 settings. Upstream logic decodes a keypad into clean single-cycle pulses. A toggle pulse chooses which setting is under edit, and raise and lower pulses move the chosen setting by one step. A setting that is already at a limit stays there.

A free-running carrier counter counts system clocks. The output is high while the counter is below a compare count. A table, computed when the design is elaborated, gives the period in clocks for each frequency step. The compare count is that period scaled by the duty step over 40. A new period and compare pair takes effect only when a carrier period begins, so a setting change can never cut a pulse short or stretch it. When the enable input is low, the output is held low and the counter is held at zero.

Top module: `step_pwm`

## Requirements
- R1: After reset, the frequency step is 0 (50 kHz), the duty step is 0, frequency is the setting under edit, and the output is low.
- R2: The carrier period in clocks is floor(CLK_HZ / (50 kHz + 10 kHz × f)) for frequency step f = 0..15. With a 100 MHz clock this is 2000 clocks at step 0, 833 at step 7 and 500 at step 15.
- R3: The output stays high for floor(period × d / 40) clocks at the start of each period, for duty step d = 0..36. When d is 0, the output never goes high.
- R4: A select pulse toggles the setting under edit between frequency and duty. Raise and lower pulses change only the setting under edit. A raise and a lower pulse in the same cycle change nothing.
- R5: The frequency step saturates at both ends. Raising at 15 leaves 15, and lowering at 0 leaves 0.
- R6: The duty step saturates at both ends. Raising at 36 leaves 36, and lowering at 0 leaves 0.
- R7: A new period and compare count are applied only when a new carrier period starts. The high time of the period already running is unchanged.
- R8: While the enable is low, the output is low and the counter is zero. In the first cycle after the enable goes high, a fresh period starts with its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (CLK_HZ) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable. When low, the output is low and the counter is cleared |
| sel_i | input | 1 | Single-cycle pulse that toggles which setting is under edit |
| up_i | input | 1 | Single-cycle pulse that raises the setting under edit by one step |
| dn_i | input | 1 | Single-cycle pulse that lowers the setting under edit by one step |
| pwm_o | output | 1 | Gate pulse output |

## Verification
The bench measures the output at the pins. For each case it takes the number of clocks between rising edges and the number of high clocks in the period that follows. Both limits of each setting are covered: 50 kHz, 200 kHz, duty 0 and duty 36. The frequency step 7 case has a period of 833 clocks, which does not divide evenly, so the floor rounding of the compare count is checked there. Pressing beyond each limit shows that the settings saturate and do not wrap. A change made partway through a high phase shows that the running period is left intact. Dropping and then raising the enable shows that the output is forced low and that the first period starts cleanly.

// File: rtl/step_pwm_pkg.sv
package step_pwm_pkg;
  typedef enum logic {
    EDIT_FREQ = 1'b0,
    EDIT_DUTY = 1'b1
  } edit_e;
endpackage

// File: rtl/spwm_setting.sv
module spwm_setting
  import step_pwm_pkg::*;
#(
  parameter int N_FREQ = 16,
  parameter int N_DUTY = 37,
  localparam int FREQ_W = $clog2(N_FREQ),
  localparam int DUTY_W = $clog2(N_DUTY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [DUTY_W-1:0] duty_o,
  output edit_e             edit_o
);
  localparam logic [FREQ_W-1:0] FREQ_TOP = FREQ_W'(N_FREQ - 1);
  localparam logic [DUTY_W-1:0] DUTY_TOP = DUTY_W'(N_DUTY - 1);

  logic [FREQ_W-1:0] freq_q, freq_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  edit_e             edit_q, edit_d;
  logic              upd_en;

  assign upd_en = sel_i | up_i | dn_i;

  always_comb begin
    freq_d = freq_q;
    duty_d = duty_q;
    edit_d = edit_q;
    if (up_i && !dn_i) begin
      if (edit_q == EDIT_FREQ) begin
        if (freq_q != FREQ_TOP) freq_d = freq_q + FREQ_W'(1);
      end else begin
        if (duty_q != DUTY_TOP) duty_d = duty_q + DUTY_W'(1);
      end
    end else if (dn_i && !up_i) begin
      if (edit_q == EDIT_FREQ) begin
        if (freq_q != '0) freq_d = freq_q - FREQ_W'(1);
      end else begin
        if (duty_q != '0) duty_d = duty_q - DUTY_W'(1);
      end
    end
    if (sel_i) edit_d = (edit_q == EDIT_FREQ) ? EDIT_DUTY : EDIT_FREQ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= '0;
      duty_q <= '0;
      edit_q <= EDIT_FREQ;
    end else if (upd_en) begin
      freq_q <= freq_d;
      duty_q <= duty_d;
      edit_q <= edit_d;
    end
  end

  assign freq_o = freq_q;
  assign duty_o = duty_q;
  assign edit_o = edit_q;
endmodule

// File: rtl/spwm_calc.sv
module spwm_calc #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int FMIN_HZ  = 50_000,
  parameter int FSTEP_HZ = 10_000,
  parameter int N_FREQ   = 16,
  parameter int N_DUTY   = 37,
  parameter int DUTY_DEN = 40,
  localparam int FREQ_W  = $clog2(N_FREQ),
  localparam int DUTY_W  = $clog2(N_DUTY),
  localparam int PER_W   = $clog2(CLK_HZ / FMIN_HZ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [PER_W-1:0]  per_o,
  output logic [PER_W-1:0]  cmp_o
);
  localparam int PROD_W = PER_W + DUTY_W;
  localparam logic [PER_W-1:0] PER_RST = PER_W'(CLK_HZ / FMIN_HZ);

  logic [PER_W-1:0]  per_tab [N_FREQ];
  logic [PER_W-1:0]  per_d, cmp_d;
  logic [PER_W-1:0]  per_q, cmp_q;
  logic [PROD_W-1:0] prod;

  for (genvar g = 0; g < N_FREQ; g++) begin : g_per_tab
    assign per_tab[g] = PER_W'(CLK_HZ / (FMIN_HZ + g * FSTEP_HZ));
  end

  always_comb begin
    per_d = per_tab[freq_i];
    prod  = PROD_W'(per_d) * PROD_W'(duty_i);
    cmp_d = PER_W'(prod / PROD_W'(DUTY_DEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= PER_RST;
      cmp_q <= '0;
    end else begin
      per_q <= per_d;
      cmp_q <= cmp_d;
    end
  end

  assign per_o = per_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int PER_W = 11,
  parameter logic [PER_W-1:0] PER_RST = PER_W'(2000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] cmp_i,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] cmp_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_act_q, per_act_d;
  logic [PER_W-1:0] cmp_act_q, cmp_act_d;
  logic             wrap, load;

  always_comb begin
    wrap      = (cnt_q == per_act_q - PER_W'(1));
    load      = !en_i || wrap;
    cnt_d     = load ? '0 : cnt_q + PER_W'(1);
    per_act_d = load ? per_i : per_act_q;
    cmp_act_d = load ? cmp_i : cmp_act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      per_act_q <= PER_RST;
      cmp_act_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      per_act_q <= per_act_d;
      cmp_act_q <= cmp_act_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_act_q;
endmodule

// File: rtl/step_pwm.sv
module step_pwm
  import step_pwm_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int FMIN_HZ  = 50_000,
  parameter int FSTEP_HZ = 10_000,
  parameter int N_FREQ   = 16,
  parameter int N_DUTY   = 37,
  parameter int DUTY_DEN = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  input  logic up_i,
  input  logic dn_i,
  output logic pwm_o
);
  localparam int FREQ_W = $clog2(N_FREQ);
  localparam int DUTY_W = $clog2(N_DUTY);
  localparam int PER_W  = $clog2(CLK_HZ / FMIN_HZ + 1);
  localparam logic [PER_W-1:0] PER_RST = PER_W'(CLK_HZ / FMIN_HZ);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [FREQ_W-1:0] freq_idx;
  logic [DUTY_W-1:0] duty_idx;
  edit_e             edit_q;
  logic [PER_W-1:0]  per_new, cmp_new;
  logic [PER_W-1:0]  cnt, cmp_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  spwm_setting #(.N_FREQ(N_FREQ), .N_DUTY(N_DUTY)) u_setting (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .sel_i (sel_i),
    .up_i  (up_i),
    .dn_i  (dn_i),
    .freq_o(freq_idx),
    .duty_o(duty_idx),
    .edit_o(edit_q)
  );

  spwm_calc #(
    .CLK_HZ(CLK_HZ), .FMIN_HZ(FMIN_HZ), .FSTEP_HZ(FSTEP_HZ),
    .N_FREQ(N_FREQ), .N_DUTY(N_DUTY), .DUTY_DEN(DUTY_DEN)
  ) u_calc (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .freq_i(freq_idx),
    .duty_i(duty_idx),
    .per_o (per_new),
    .cmp_o (cmp_new)
  );

  spwm_carrier #(.PER_W(PER_W), .PER_RST(PER_RST)) u_carrier (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .en_i  (en_i),
    .per_i (per_new),
    .cmp_i (cmp_new),
    .cnt_o (cnt),
    .cmp_o (cmp_act)
  );

  assign pwm_o = en_i && (cnt < cmp_act);
endmodule

// File: rtl/step_pwm_chk.sv
module step_pwm_chk
  import step_pwm_pkg::*;
#(
  parameter int N_FREQ = 16,
  parameter int N_DUTY = 37,
  parameter int PER_W  = 11,
  localparam int FREQ_W = $clog2(N_FREQ),
  localparam int DUTY_W = $clog2(N_DUTY)
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              en_i,
  input logic              sel_i,
  input logic              up_i,
  input logic              dn_i,
  input logic              pwm_o,
  input logic [FREQ_W-1:0] freq_idx,
  input logic [DUTY_W-1:0] duty_idx,
  input edit_e             edit,
  input logic [PER_W-1:0]  cnt,
  input logic [PER_W-1:0]  cmp_act
);
  // R8
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |-> !pwm_o);
  // R8
  off_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (cnt == '0));
  // R4
  sel_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sel_i |=> (edit != $past(edit)));
  // R4
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edit == EDIT_DUTY) |=> $stable(freq_idx));
  // R4
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edit == EDIT_FREQ) |=> $stable(duty_idx));
  // R5
  freq_top_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edit == EDIT_FREQ && up_i && !dn_i && freq_idx == FREQ_W'(N_FREQ - 1))
      |=> (freq_idx == FREQ_W'(N_FREQ - 1)));
  // R5
  freq_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edit == EDIT_FREQ && dn_i && !up_i && freq_idx == '0) |=> (freq_idx == '0));
  // R6
  duty_top_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edit == EDIT_DUTY && up_i && !dn_i && duty_idx == DUTY_W'(N_DUTY - 1))
      |=> (duty_idx == DUTY_W'(N_DUTY - 1)));
  // R6
  duty_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edit == EDIT_DUTY && dn_i && !up_i && duty_idx == '0) |=> (duty_idx == '0));
  // R7
  cmp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(cmp_act) |-> (cnt == '0));
  // R3
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmp_act == '0) |-> !pwm_o);
endmodule

bind step_pwm step_pwm_chk #(.N_FREQ(N_FREQ), .N_DUTY(N_DUTY), .PER_W(PER_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n_s),
  .en_i    (en_i),
  .sel_i   (sel_i),
  .up_i    (up_i),
  .dn_i    (dn_i),
  .pwm_o   (pwm_o),
  .freq_idx(freq_idx),
  .duty_idx(duty_idx),
  .edit    (edit_q),
  .cnt     (cnt),
  .cmp_act (cmp_act)
);

// File: tb/test_step_pwm.sv
`timescale 1ns/1ps
module test_step_pwm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sel = 1'b0, up = 1'b0, dn = 1'b0;
  logic pwm;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  step_pwm i_step_pwm (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .sel_i(sel), .up_i(up), .dn_i(dn), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press_sel();
    @(negedge clk) sel = 1'b1;
    @(negedge clk) sel = 1'b0;
  endtask

  task automatic press_up(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) up = 1'b1;
      @(negedge clk) up = 1'b0;
    end
  endtask

  task automatic press_dn(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dn = 1'b1;
      @(negedge clk) dn = 1'b0;
    end
  endtask

  task automatic wait_rise();
    int guard = 0;
    @(negedge clk);
    while (pwm !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    while (pwm !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    int guard = 0;
    wait_rise();
    per = 0; hi = 0; prev = 1'b0;
    do begin
      if (pwm) hi++;
      per++;
      prev = pwm;
      @(negedge clk);
      guard++;
    end while (!(pwm === 1'b1 && prev === 1'b0) && guard < 5000);
  endtask

  task automatic settled(output int per, output int hi);
    int p0, h0;
    measure(p0, h0);
    measure(per, hi);
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic t_reset();
    int hi;
    rst_n = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R1 output during reset", pwm, 0);
    rst_n = 1'b1;
    count_high(2100, hi);
    check(hi == 0, "R1 duty 0 after reset", hi, 0);
  endtask

  task automatic t_default_freq();
    int per, hi;
    press_sel();
    press_up(20);
    settled(per, hi);
    check(per == 2000, "R2 R1 period at step 0", per, 2000);
    check(hi == 1000, "R3 R4 high at duty 20", hi, 1000);
  endtask

  task automatic t_freq_top();
    int per, hi;
    press_sel();
    press_up(15);
    settled(per, hi);
    check(per == 500, "R2 R4 period at step 15", per, 500);
    check(hi == 250, "R3 high at step 15 duty 20", hi, 250);
    press_up(3);
    settled(per, hi);
    check(per == 500, "R5 saturate at top", per, 500);
  endtask

  task automatic t_freq_bottom();
    int per, hi;
    press_dn(20);
    settled(per, hi);
    check(per == 2000, "R5 saturate at bottom", per, 2000);
    check(hi == 1000, "R4 duty unchanged by freq edits", hi, 1000);
  endtask

  task automatic t_odd_period();
    int per, hi;
    press_up(7);
    settled(per, hi);
    check(per == 833, "R2 period at step 7", per, 833);
    check(hi == 416, "R3 floor at step 7 duty 20", hi, 416);
  endtask

  task automatic t_both_pressed();
    int per, hi;
    @(negedge clk) begin up = 1'b1; dn = 1'b1; end
    @(negedge clk) begin up = 1'b0; dn = 1'b0; end
    settled(per, hi);
    check(per == 833, "R4 up and down together ignored", per, 833);
  endtask

  task automatic t_duty_top();
    int per, hi;
    press_sel();
    press_up(20);
    settled(per, hi);
    check(hi == 749, "R6 R3 duty saturates at 36", hi, 749);
    check(per == 833, "R4 period unchanged by duty edits", per, 833);
  endtask

  task automatic t_midperiod();
    int per, hi, run;
    press_sel();
    press_dn(7);
    press_sel();
    settled(per, hi);
    check(hi == 1800, "R3 high at step 0 duty 36", hi, 1800);
    wait_rise();
    run = 1;
    fork
      begin
        @(negedge clk);
        while (pwm) begin run++; @(negedge clk); end
      end
      begin
        repeat (100) @(negedge clk);
        press_dn(16);
      end
    join
    check(run == 1800, "R7 running period untouched", run, 1800);
    measure(per, hi);
    check(hi == 1000, "R7 new duty at next period", hi, 1000);
  endtask

  task automatic t_duty_zero();
    int hi;
    press_dn(40);
    repeat (2100) @(negedge clk);
    count_high(2100, hi);
    check(hi == 0, "R6 R3 duty 0 gives no pulse", hi, 0);
  endtask

  task automatic t_enable();
    int hi, run;
    press_up(20);
    repeat (4100) @(negedge clk);
    @(negedge clk) en = 1'b0;
    count_high(60, hi);
    check(hi == 0, "R8 output low while disabled", hi, 0);
    en = 1'b1;
    #1;
    check(pwm == 1'b1, "R8 high at once on enable", pwm, 1);
    run = 1;
    @(negedge clk);
    while (pwm && run < 5000) begin run++; @(negedge clk); end
    check(run == 1000, "R8 fresh period after enable", run, 1000);
  endtask

  initial begin
    t_reset();
    t_default_freq();
    t_freq_top();
    t_freq_bottom();
    t_odd_period();
    t_both_pressed();
    t_duty_top();
    t_midperiod();
    t_duty_zero();
    t_enable();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule